// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (SMBus/I2C) that holds a bank of eleven 8-bit configuration registers and hands their contents to the rest of the chip as one flat vector. A controller reaches the bank through four transfer kinds: single-byte write, single-byte read, sequential block write and sequential block read. The command byte sent after the device address picks the kind. With its most significant bit set, the command addresses one register, and bits 6:0 hold the register offset. With that bit clear, the command starts a block transfer at offset 0.

Block writes normally carry a byte-count byte ahead of the data. A mode bit kept in the bank itself can drop this byte. Block reads return the register count first and then the registers in ascending order. Two fields cannot be written over the bus: an identification byte, and a 3-bit strap field that is captured from input pins once after reset.

Both bus lines are oversampled by the system clock. Start and stop conditions are detected from SDA edges while SCL is high. The slave pulls SDA low only in acknowledge slots and in read-data bit slots.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset, the register bank holds the following values. Register k is presented on `cfgOut[8k+7:8k]`. The values are: reg0 0xFF, reg1 0xFE, reg2 0xFF, reg3 0x00, reg4 0x07, reg5 0x00, reg6 0x18 in bits 7:3, reg7 0x08, reg8 0x44, reg9 0x0E, reg10 0x00.
- R2: The slave acknowledges only the 7-bit address 0x69, which is sent as 0xD2 for a write and 0xD3 for a read. Any other address gets no acknowledge, and no register changes.
- R3: Single-byte write: start, 0xD2, a command with bit 7 = 1 and the offset in bits 6:0, one data byte, stop. This writes the data byte to that register, and each of the three bytes is acknowledged.
- R4: Single-byte read: start, 0xD2, the command, repeated start, 0xD3, then the slave sends the addressed register MSB first; the master NACKs and stops.
- R5: Block write: start, 0xD2, command 0x00, one byte-count byte whose value is ignored, then data bytes. The data bytes go to reg0, reg1 and so on in order. When the master stops after n data bytes, registers n and above keep their values.
- R6: When bit 7 of reg10 is 1, a block write has no byte-count byte, and the first byte after command 0x00 goes to reg0.
- R7: Block read (command 0x00, repeated start, 0xD3): the first byte returned is the register count 0x0B, followed by reg0, reg1 and so on. The master's NACK ends the transfer.
- R8: reg7 always reads 0x08. A write to offset 7 is acknowledged and has no effect.
- R9: reg6 bits 2:0 hold `strapIn` as captured in the first clock after reset. Later changes on `strapIn` and bus writes do not alter these bits. Bits 7:3 of reg6 are writable.
- R10: A data byte addressed to offset 11 or above is not acknowledged and changes no register.
- R11: The slave drives SDA only during a transfer addressed to it, and it releases SDA after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| strapIn | input | 3 | Strap levels, captured once after reset into reg6 bits 2:0 |
| sdaOe | output | 1 | Pull SDA low when 1 (open-drain drive) |
| cfgOut | output | 88 | Register bank, with reg k in bits 8k+7:8k |

## Verification
The bench sweeps every offset with byte writes and byte reads.

- If the write mask is wrong, the sweep corrupts the identification byte or the strap bits.
- If the bank is off by one, the sweep stores bytes in the wrong register.

It runs a full block write and a truncated block write.

- If a design writes past the stop point, the registers above the last byte sent change.
- If the byte-count byte is mishandled, the truncated write is shifted by one register.

The count-skip mode is exercised on its own: a design that ignores the mode bit writes the first data byte nowhere and shifts every later byte down by one.

Block reads must start with the count byte, and bytes aimed beyond the bank must be refused. A design that gets these wrong returns the bank one byte early, or acknowledges and corrupts state.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;

  localparam int NUM_REGS     = 11;
  localparam int IDX_W        = $clog2(NUM_REGS);
  localparam int STRAP_W      = 3;
  localparam int STRAP_OFFSET = 6;
  localparam int ID_OFFSET    = 7;
  localparam int MODE_OFFSET  = 10;
  localparam int MODE_BIT     = 7;

  // Strobes from the bus control to the register datapath.
  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [7:0]       wrData;
    logic [IDX_W-1:0] rdIdx;
  } regStrobe_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACKOUT, PH_TX, PH_ACKIN
  } phase_e;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_CNT, K_DATA
  } kind_e;

  function automatic logic [7:0] resetValue(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFE;
      2:       return 8'hFF;
      4:       return 8'h07;
      6:       return 8'h18;
      7:       return 8'h08;
      8:       return 8'h44;
      9:       return 8'h0E;
      default: return 8'h00;
    endcase
  endfunction

  // Bits that the bus may change; the rest are read-only.
  function automatic logic [7:0] writeMask(input int idx);
    case (idx)
      ID_OFFSET:    return 8'h00;
      STRAP_OFFSET: return 8'hF8;
      default:      return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/twi_reg_sync.sv
module twi_reg_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncNow,
  output logic [WIDTH-1:0] syncPrev
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [2:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= 3'b111;
      else       stage <= {stage[1:0], rawIn[b]};
    end
    assign syncNow[b]  = stage[1];
    assign syncPrev[b] = stage[2];
  end

endmodule

// File: rtl/twi_reg_ctrl.sv
module twi_reg_ctrl
  import twi_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclNow,
  input  logic       sclPrev,
  input  logic       sdaNow,
  input  logic       sdaPrev,
  input  logic       skipCount,
  input  logic [7:0] rdData,
  output regStrobe_t strb,
  output logic       sdaOe,
  output logic       active
);

  localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);

  phase_e     phase;
  kind_e      kind;
  logic [3:0] bitCnt;
  logic [7:0] rxSh;
  logic [7:0] txSh;
  logic [7:0] ptr;
  logic       byteMode;
  logic       rwRead;
  logic       cntPending;
  logic       masterAck;
  logic       wrEn;
  logic [IDX_W-1:0] wrIdx;
  logic [7:0] wrData;

  logic sclRise, sclFall, startSeen, stopSeen, inRange;
  logic [7:0] nextTx;

  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign inRange   = ptr < REG_LIMIT;
  assign nextTx    = cntPending ? REG_LIMIT : (inRange ? rdData : 8'h00);
  assign active    = phase != PH_IDLE;

  always_comb begin
    strb.wrEn   = wrEn;
    strb.wrIdx  = wrIdx;
    strb.wrData = wrData;
    strb.rdIdx  = ptr[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      kind       <= K_ADDR;
      bitCnt     <= '0;
      rxSh       <= '0;
      txSh       <= '0;
      ptr        <= '0;
      byteMode   <= 1'b0;
      rwRead     <= 1'b0;
      cntPending <= 1'b0;
      masterAck  <= 1'b0;
      sdaOe      <= 1'b0;
      wrEn       <= 1'b0;
      wrIdx      <= '0;
      wrData     <= '0;
    end else begin
      wrEn <= 1'b0;
      if (startSeen) begin
        phase  <= PH_RX;
        kind   <= K_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopSeen) begin
        phase <= PH_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (sclRise) begin
              rxSh   <= {rxSh[6:0], sdaNow};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (rxSh[7:1] == DEV_ADDR) begin
                    rwRead     <= rxSh[0];
                    cntPending <= rxSh[0] & ~byteMode;
                    sdaOe      <= 1'b1;
                    phase      <= PH_ACKOUT;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                K_CMD: begin
                  sdaOe    <= 1'b1;
                  phase    <= PH_ACKOUT;
                  byteMode <= rxSh[7];
                  ptr      <= rxSh[7] ? {1'b0, rxSh[6:0]} : 8'h00;
                  kind     <= (rxSh[7] || skipCount) ? K_DATA : K_CNT;
                end
                K_CNT: begin
                  sdaOe <= 1'b1;
                  phase <= PH_ACKOUT;
                  kind  <= K_DATA;
                end
                default: begin
                  if (inRange) begin
                    sdaOe  <= 1'b1;
                    phase  <= PH_ACKOUT;
                    wrEn   <= 1'b1;
                    wrIdx  <= ptr[IDX_W-1:0];
                    wrData <= rxSh;
                    ptr    <= ptr + 8'd1;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
              endcase
            end
          end
          PH_ACKOUT: begin
            if (sclFall) begin
              if (kind == K_ADDR && rwRead) begin
                txSh   <= nextTx;
                sdaOe  <= ~nextTx[7];
                bitCnt <= '0;
                phase  <= PH_TX;
                if (cntPending) cntPending <= 1'b0;
                else            ptr <= ptr + 8'd1;
              end else begin
                sdaOe <= 1'b0;
                phase <= PH_RX;
                if (kind == K_ADDR) kind <= K_CMD;
              end
            end
          end
          PH_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                sdaOe  <= 1'b0;
                bitCnt <= '0;
                phase  <= PH_ACKIN;
              end else begin
                bitCnt <= bitCnt + 4'd1;
                txSh   <= {txSh[6:0], 1'b0};
                sdaOe  <= ~txSh[6];
              end
            end
          end
          PH_ACKIN: begin
            if (sclRise) begin
              masterAck <= ~sdaNow;
            end else if (sclFall) begin
              if (masterAck) begin
                txSh   <= nextTx;
                sdaOe  <= ~nextTx[7];
                bitCnt <= '0;
                phase  <= PH_TX;
                if (cntPending) cntPending <= 1'b0;
                else            ptr <= ptr + 8'd1;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_reg_data.sv
module twi_reg_data
  import twi_reg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [STRAP_W-1:0]    strapIn,
  output logic [7:0]            rdData,
  output logic                  skipCount,
  output logic [NUM_REGS*8-1:0] cfgOut
);

  logic [7:0]         regQ [NUM_REGS];
  logic [7:0]         view [NUM_REGS];
  logic [STRAP_W-1:0] strapQ;
  logic               strapTaken;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ     <= '0;
      strapTaken <= 1'b0;
    end else if (!strapTaken) begin
      strapQ     <= strapIn;
      strapTaken <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_VAL = resetValue(i);
    localparam logic [7:0] WR_MASK = writeMask(i);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[i] <= RST_VAL;
      else if (strb.wrEn && strb.wrIdx == IDX_W'(i))
        regQ[i] <= (regQ[i] & ~WR_MASK) | (strb.wrData & WR_MASK);
    end

    if (i == STRAP_OFFSET) begin : g_strap
      assign view[i] = {regQ[i][7:STRAP_W], strapQ};
    end else begin : g_plain
      assign view[i] = regQ[i];
    end

    assign cfgOut[8*i +: 8] = view[i];
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (strb.rdIdx == IDX_W'(i)) rdData = view[i];
  end

  assign skipCount = regQ[MODE_OFFSET][MODE_BIT];

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [STRAP_W-1:0]    strapIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] cfgOut
);

  logic [1:0] lineNow, linePrev;
  regStrobe_t strb;
  logic [7:0] rdData;
  logic       skipCount;
  logic       ctrlActive;

  twi_reg_sync #(.WIDTH(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({sclIn, sdaIn}),
    .syncNow (lineNow),
    .syncPrev(linePrev)
  );

  twi_reg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclNow   (lineNow[1]),
    .sclPrev  (linePrev[1]),
    .sdaNow   (lineNow[0]),
    .sdaPrev  (linePrev[0]),
    .skipCount(skipCount),
    .rdData   (rdData),
    .strb     (strb),
    .sdaOe    (sdaOe),
    .active   (ctrlActive)
  );

  twi_reg_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .strapIn  (strapIn),
    .rdData   (rdData),
    .skipCount(skipCount),
    .cfgOut   (cfgOut)
  );

endmodule

// File: rtl/twi_reg_checker.sv
module twi_reg_checker
  import twi_reg_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  sdaOe,
  input logic                  active,
  input regStrobe_t            strb,
  input logic [NUM_REGS*8-1:0] cfgOut
);

  logic [1:0] sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceReset <= 2'd0;
    else if (sinceReset != 2'd2) sinceReset <= sinceReset + 2'd1;
  end

  assert_oob_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (strb.wrIdx < IDX_W'(NUM_REGS)));

  assert_id_fixed_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgOut[ID_OFFSET*8 +: 8] == 8'h08);

  assert_strap_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd2) |-> $stable(cfgOut[STRAP_OFFSET*8 +: STRAP_W]));

  assert_bus_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !sdaOe);

  assert_single_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> !strb.wrEn);

endmodule

bind twi_reg_slave twi_reg_checker u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .sdaOe (sdaOe),
  .active(ctrlActive),
  .strb  (strb),
  .cfgOut(cfgOut)
);

// File: tb/twi_reg_slave_test.sv
module twi_reg_slave_test;

  localparam int N = 11;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mLow = 1'b0;
  logic [2:0] strapIn = 3'b101;
  logic sdaOe;
  logic [N*8-1:0] cfg;
  logic sdaLine;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] model [N];

  assign sdaLine = ~(mLow | sdaOe);

  always #10 clk = ~clk;

  twi_reg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .strapIn(strapIn), .sdaOe(sdaOe), .cfgOut(cfg)
  );

  function automatic logic [7:0] defOf(int i);
    logic [7:0] d [N] = '{8'hFF, 8'hFE, 8'hFF, 8'h00, 8'h07, 8'h00,
                          8'h1D, 8'h08, 8'h44, 8'h0E, 8'h00};
    return d[i];
  endfunction

  function automatic logic [7:0] maskOf(int i);
    if (i == 7) return 8'h00;
    if (i == 6) return 8'hF8;
    return 8'hFF;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    mLow = 0; tick(H); scl = 1; tick(H); mLow = 1; tick(H); scl = 0; tick(2);
  endtask

  task automatic busStop;
    mLow = 1; tick(H); scl = 1; tick(H); mLow = 0; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mLow = ~b[i]; tick(H); scl = 1; tick(H); scl = 0; tick(2);
    end
    mLow = 0; tick(H); scl = 1; tick(H/2); ack = ~sdaLine; tick(H/2);
    scl = 0; tick(2);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    mLow = 0;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1; tick(H/2); b[i] = sdaLine; tick(H/2); scl = 0; tick(2);
    end
    mLow = ackIt; tick(H); scl = 1; tick(H); scl = 0; tick(2); mLow = 0;
  endtask

  task automatic writeOne(int off, logic [7:0] v, output logic a0, a1, a2);
    busStart;
    sendByte(8'hD2, a0);
    sendByte({1'b1, 7'(off)}, a1);
    sendByte(v, a2);
    busStop;
  endtask

  task automatic readOne(int off, output logic [7:0] v, output logic ok);
    logic a0, a1, a2;
    busStart;
    sendByte(8'hD2, a0);
    sendByte({1'b1, 7'(off)}, a1);
    busStart;
    sendByte(8'hD3, a2);
    recvByte(1'b0, v);
    busStop;
    ok = a0 & a1 & a2;
  endtask

  task automatic checkBank(string tag);
    for (int i = 0; i < N; i++) check(tag, cfg[8*i +: 8], model[i]);
  endtask

  task automatic blockWrite(int n, logic [7:0] base, output logic allAck);
    logic a;
    logic [7:0] v;
    allAck = 1;
    busStart;
    sendByte(8'hD2, a); allAck &= a;
    sendByte(8'h00, a); allAck &= a;
    if (!model[10][7]) begin sendByte(8'(n), a); allAck &= a; end
    for (int i = 0; i < n; i++) begin
      v = base ^ 8'(i * 29);
      if (i == 10) v[7] = 1'b0;
      sendByte(v, a); allAck &= a;
      model[i] = (model[i] & ~maskOf(i)) | (v & maskOf(i));
    end
    busStop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R11 watchdog expired got=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, ok;
    logic [7:0] v, cnt;
    tick(5); rstN = 1; tick(5);

    // R1 reset contents (strap 101 in reg6 bits 2:0)
    for (int i = 0; i < N; i++) model[i] = defOf(i);
    checkBank("R1 reset value");
    check("R11 idle release", {7'b0, sdaOe}, 8'h00);

    // R3 / R8 / R9 byte write sweep over every offset
    for (int i = 0; i < N; i++) begin
      v = 8'(i * 53 + 17);
      if (i == 10) v[7] = 1'b0;
      writeOne(i, v, a0, a1, a2);
      model[i] = (model[i] & ~maskOf(i)) | (v & maskOf(i));
      check(i == 7 ? "R8 id write ack" : "R3 write ack", {5'b0, a0, a1, a2}, 8'h07);
      check(i == 7 ? "R8 id unchanged" : (i == 6 ? "R9 strap masked" : "R3 byte write"),
            cfg[8*i +: 8], model[i]);
      check("R11 released after stop", {7'b0, sdaOe}, 8'h00);
    end

    // R4 byte read sweep
    for (int i = 0; i < N; i++) begin
      readOne(i, v, ok);
      check("R4 read ack", {7'b0, ok}, 8'h01);
      check("R4 byte read", v, model[i]);
    end

    // R2 foreign addresses
    busStart; sendByte(8'hA0, a0); busStop;
    check("R2 foreign address nack", {7'b0, a0}, 8'h00);
    busStart; sendByte(8'hD0, a0); sendByte(8'h80, a1); busStop;
    check("R2 near address nack", {7'b0, a0}, 8'h00);
    checkBank("R2 bank unchanged");

    // R10 offset beyond bank
    writeOne(11, 8'h00, a0, a1, a2);
    check("R10 data nack", {5'b0, a0, a1, a2}, 8'h06);
    writeOne(100, 8'h00, a0, a1, a2);
    check("R10 far offset nack", {7'b0, a2}, 8'h00);
    checkBank("R10 bank unchanged");

    // R5 full and truncated block writes
    blockWrite(N, 8'hC3, ok);
    check("R5 block ack", {7'b0, ok}, 8'h01);
    checkBank("R5 full block");
    blockWrite(3, 8'h3C, ok);
    check("R5 partial ack", {7'b0, ok}, 8'h01);
    checkBank("R5 partial block");

    // R6 countless block write
    writeOne(10, 8'h80, a0, a1, a2);
    model[10] = 8'h80;
    blockWrite(4, 8'h96, ok);
    check("R6 countless ack", {7'b0, ok}, 8'h01);
    checkBank("R6 countless block");
    writeOne(10, 8'h00, a0, a1, a2);
    model[10] = 8'h00;

    // R7 block read
    busStart;
    sendByte(8'hD2, a0); sendByte(8'h00, a1);
    busStart; sendByte(8'hD3, a2);
    recvByte(1'b1, cnt);
    check("R7 count first", cnt, 8'h0B);
    for (int i = 0; i < N; i++) begin
      recvByte(i != N - 1, v);
      check("R7 block read", v, model[i]);
    end
    busStop;
    check("R7 released", {7'b0, sdaOe}, 8'h00);

    // R9 strap pins changed later and reg6 cleared over the bus
    strapIn = 3'b010; tick(4);
    writeOne(6, 8'h00, a0, a1, a2);
    model[6] = 8'h05;
    check("R9 strap held", cfg[8*6 +: 8], 8'h05);
    readOne(6, v, ok);
    check("R9 strap readback", v, 8'h05);
    readOne(7, v, ok);
    check("R8 id readback", v, 8'h08);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule